// File: doc/BRIEF.md
# Conditional Branch Decoder

This block looks at one 32-bit instruction word and decides whether it is a branch-class instruction. If it is, the block tests the word's 4-bit condition field against the current arithmetic flags (negative, zero, carry, overflow) and reports whether the branch is taken. It forms the destination address by sign-extending the 24-bit word offset, scaling it by four, and adding it to the supplied PC value. For the linking form, it also produces a return address and a write strobe for the link register.

The block sits between instruction decode and the fetch redirect logic. The PC input is the branch's own address plus 8, which is the usual prefetch offset. The return address is the PC input minus 4, so it points at the instruction after the branch. The logic is combinational. An optional output register stage, selected by a parameter and enabled by default, places all five results one clock after the inputs that produced them.

Top module: `brdec_unit`

## Requirements
- R1: `is_branch_o` is high exactly when instruction bits 27:25 equal binary 101.
- R2: Condition bits 31:28 are tested against `flags_i` = {N, Z, C, V} (bit 3 down to bit 0) as follows. 0:Z. 1:!Z. 2:C. 3:!C. 4:N. 5:!N. 6:V. 7:!V. 8:C&!Z. 9:!C\|Z. 10:N==V. 11:N!=V. 12:!Z&(N==V). 13:Z\|(N!=V).
- R3: Condition code 14 passes for every flag value, and condition code 15 never passes.
- R4: `taken_o` is high exactly when the word is a branch and its condition passes.
- R5: `target_o` equals PC plus the 24-bit offset in bits 23:0, sign-extended and multiplied by four, taken modulo 2^32. It is produced whether or not the branch is taken.
- R6: Offset 0x7FFFFF reaches PC + 0x1FFFFFC, and offset 0x800000 reaches PC - 0x2000000. These are the two ends of the +/-32 MB window.
- R7: `link_value_o` equals the PC input minus 4.
- R8: `link_we_o` is high only when the word is a branch, bit 24 (the link bit) is 1, and the condition passes.
- R9: With the output register enabled, every output reflects the inputs of the previous clock. During reset, all outputs are zero.
- R10: A word that is not branch-class never raises `taken_o` or `link_we_o`, whatever its condition and flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_i | input | 32 | Instruction word under decode |
| pc_i | input | 32 | PC value, equal to the branch address plus 8 |
| flags_i | input | 4 | Flags {N, Z, C, V} |
| taken_o | output | 1 | Branch-class word whose condition passes |
| target_o | output | 32 | Computed branch destination |
| link_we_o | output | 1 | Link register write strobe |
| link_value_o | output | 32 | Return address for the link register |
| is_branch_o | output | 1 | Word is branch-class |

## Verification
The only state in the block is the output register, so any fault shows up at the ports one clock after the offending input. A misdecoded condition shows up as a wrong `taken_o` for a specific code and flag pattern. The bench therefore sweeps all 256 combinations of condition code and flag value. A sign-extension or scaling error corrupts `target_o` only for some offsets, so the two ends of the range and a wrap past 2^32 are driven explicitly. A register that holds a stale value or clears wrongly is caught because every cycle is compared against the inputs of the cycle before.

// File: rtl/brdec_pkg.sv
package brdec_pkg;

    localparam int unsigned ADDR_W = 32;

    typedef enum logic [3:0] {
        COND_EQ = 4'h0, COND_NE = 4'h1, COND_CS = 4'h2, COND_CC = 4'h3,
        COND_MI = 4'h4, COND_PL = 4'h5, COND_VS = 4'h6, COND_VC = 4'h7,
        COND_HI = 4'h8, COND_LS = 4'h9, COND_GE = 4'hA, COND_LT = 4'hB,
        COND_GT = 4'hC, COND_LE = 4'hD, COND_AL = 4'hE, COND_NV = 4'hF
    } cond_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    typedef struct packed {
        logic              taken;
        logic [ADDR_W-1:0] target;
        logic              link_we;
        logic [ADDR_W-1:0] link_value;
        logic              is_branch;
    } brdec_out_t;

endpackage

// File: rtl/brdec_fields.sv
module brdec_fields
    import brdec_pkg::*;
#(
    parameter int unsigned OFFSET_W  = 24,
    parameter logic [2:0]  CLASS_VAL = 3'b101
) (
    input  logic [ADDR_W-1:0]   instr_i,
    output logic [3:0]          cond_o,
    output logic                class_hit_o,
    output logic                link_bit_o,
    output logic [OFFSET_W-1:0] offset_o
);
    localparam int unsigned LINK_POS  = OFFSET_W;
    localparam int unsigned CLASS_LSB = OFFSET_W + 1;
    localparam int unsigned COND_LSB  = ADDR_W - 4;

    always_comb begin
        cond_o      = instr_i[COND_LSB +: 4];
        class_hit_o = (instr_i[CLASS_LSB +: 3] == CLASS_VAL);
        link_bit_o  = instr_i[LINK_POS];
        offset_o    = instr_i[OFFSET_W-1:0];
    end
endmodule

// File: rtl/brdec_cond_eval.sv
module brdec_cond_eval
    import brdec_pkg::*;
(
    input  logic [3:0] cond_i,
    input  flags_t     flags_i,
    output logic       pass_o
);
    logic sign_match;

    always_comb begin
        sign_match = (flags_i.n == flags_i.v);
        case (cond_e'(cond_i))
            COND_EQ: pass_o = flags_i.z;
            COND_NE: pass_o = !flags_i.z;
            COND_CS: pass_o = flags_i.c;
            COND_CC: pass_o = !flags_i.c;
            COND_MI: pass_o = flags_i.n;
            COND_PL: pass_o = !flags_i.n;
            COND_VS: pass_o = flags_i.v;
            COND_VC: pass_o = !flags_i.v;
            COND_HI: pass_o = flags_i.c && !flags_i.z;
            COND_LS: pass_o = !flags_i.c || flags_i.z;
            COND_GE: pass_o = sign_match;
            COND_LT: pass_o = !sign_match;
            COND_GT: pass_o = !flags_i.z && sign_match;
            COND_LE: pass_o = flags_i.z || !sign_match;
            COND_AL: pass_o = 1'b1;
            default: pass_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/brdec_target.sv
module brdec_target
    import brdec_pkg::*;
#(
    parameter int unsigned OFFSET_W = 24,
    parameter int unsigned SHIFT    = 2,
    parameter int unsigned LINK_ADJ = 4
) (
    input  logic [OFFSET_W-1:0] offset_i,
    input  logic [ADDR_W-1:0]   pc_i,
    output logic [ADDR_W-1:0]   target_o,
    output logic [ADDR_W-1:0]   link_value_o
);
    localparam int unsigned EXT_W = ADDR_W - OFFSET_W - SHIFT;

    logic [ADDR_W-1:0] disp;

    always_comb begin
        disp         = {{EXT_W{offset_i[OFFSET_W-1]}}, offset_i, {SHIFT{1'b0}}};
        target_o     = pc_i + disp;
        link_value_o = pc_i - ADDR_W'(LINK_ADJ);
    end
endmodule

// File: rtl/brdec_unit.sv
module brdec_unit
    import brdec_pkg::*;
#(
    parameter int unsigned OFFSET_W = 24,
    parameter int unsigned SHIFT    = 2,
    parameter int unsigned LINK_ADJ = 4,
    parameter bit          REG_OUT  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] instr_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [3:0]        flags_i,
    output logic              taken_o,
    output logic [ADDR_W-1:0] target_o,
    output logic              link_we_o,
    output logic [ADDR_W-1:0] link_value_o,
    output logic              is_branch_o
);
    logic [3:0]          cond;
    logic                class_hit;
    logic                link_bit;
    logic [OFFSET_W-1:0] offset;
    logic                cond_pass;
    logic [ADDR_W-1:0]   target;
    logic [ADDR_W-1:0]   link_value;
    brdec_out_t          out_d;
    brdec_out_t          out_q;

    brdec_fields #(.OFFSET_W(OFFSET_W)) u_fields (
        .instr_i     (instr_i),
        .cond_o      (cond),
        .class_hit_o (class_hit),
        .link_bit_o  (link_bit),
        .offset_o    (offset)
    );

    brdec_cond_eval u_cond (
        .cond_i  (cond),
        .flags_i (flags_t'(flags_i)),
        .pass_o  (cond_pass)
    );

    brdec_target #(
        .OFFSET_W (OFFSET_W),
        .SHIFT    (SHIFT),
        .LINK_ADJ (LINK_ADJ)
    ) u_target (
        .offset_i     (offset),
        .pc_i         (pc_i),
        .target_o     (target),
        .link_value_o (link_value)
    );

    always_comb begin
        out_d            = '0;
        out_d.is_branch  = class_hit;
        out_d.taken      = class_hit && cond_pass;
        out_d.link_we    = class_hit && cond_pass && link_bit;
        out_d.target     = target;
        out_d.link_value = link_value;
    end

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) out_q <= '0;
                else        out_q <= out_d;
            end
        end else begin : g_comb
            assign out_q = out_d;
        end
    endgenerate

    assign taken_o      = out_q.taken;
    assign target_o     = out_q.target;
    assign link_we_o    = out_q.link_we;
    assign link_value_o = out_q.link_value;
    assign is_branch_o  = out_q.is_branch;
endmodule

// File: rtl/brdec_unit_chk.sv
module brdec_unit_chk #(
    parameter bit REG_OUT = 1'b1
) (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] instr_i,
    input logic [31:0] pc_i,
    input logic [3:0]  flags_i,
    input logic        taken_o,
    input logic [31:0] target_o,
    input logic        link_we_o,
    input logic [31:0] link_value_o,
    input logic        is_branch_o
);
    // R4
    taken_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |-> is_branch_o);

    // R8
    link_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_we_o |-> taken_o);

    generate
        if (REG_OUT) begin : g_seq
            // R3
            never_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (instr_i[31:28] == 4'hF) |=> !taken_o);

            // R3
            always_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (instr_i[31:28] == 4'hE && instr_i[27:25] == 3'b101) |=> taken_o);

            // R2
            eq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (instr_i[31:28] == 4'h0 && !flags_i[2]) |=> !taken_o);

            // R10
            nonbranch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (instr_i[27:25] != 3'b101) |=> (!is_branch_o && !link_we_o && !taken_o));

            // R7
            link_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> (link_value_o == $past(pc_i) - 32'd4));

            // R5
            target_chk: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> (target_o == $past(pc_i)
                          + {{6{$past(instr_i[23])}}, $past(instr_i[23:0]), 2'b00}));

            // R8
            link_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (instr_i[24] == 1'b0) |=> !link_we_o);
        end
    endgenerate
endmodule

bind brdec_unit brdec_unit_chk #(.REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/brdec_unit_tb.sv
module brdec_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr_i = '0;
    logic [31:0] pc_i = '0;
    logic [3:0]  flags_i = '0;
    logic        taken_o;
    logic [31:0] target_o;
    logic        link_we_o;
    logic [31:0] link_value_o;
    logic        is_branch_o;

    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;

    logic [66:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    brdec_unit u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .instr_i      (instr_i),
        .pc_i         (pc_i),
        .flags_i      (flags_i),
        .taken_o      (taken_o),
        .target_o     (target_o),
        .link_we_o    (link_we_o),
        .link_value_o (link_value_o),
        .is_branch_o  (is_branch_o)
    );

    function automatic bit ref_pass(input logic [3:0] code, input logic [3:0] f);
        bit n, z, c, v;
        n = f[3]; z = f[2]; c = f[1]; v = f[0];
        if (code == 4'd0)  return z;
        if (code == 4'd1)  return !z;
        if (code == 4'd2)  return c;
        if (code == 4'd3)  return !c;
        if (code == 4'd4)  return n;
        if (code == 4'd5)  return !n;
        if (code == 4'd6)  return v;
        if (code == 4'd7)  return !v;
        if (code == 4'd8)  return c && !z;
        if (code == 4'd9)  return !c || z;
        if (code == 4'd10) return n == v;
        if (code == 4'd11) return n != v;
        if (code == 4'd12) return !z && (n == v);
        if (code == 4'd13) return z || (n != v);
        if (code == 4'd14) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [66:0] ref_model(input logic [31:0] ins, input logic [31:0] pc,
                                              input logic [3:0] f);
        logic        br, tk, lw;
        int          off;
        logic [31:0] tgt, lnk;
        br  = (ins[27:25] == 3'b101);
        tk  = br && ref_pass(ins[31:28], f);
        lw  = tk && ins[24];
        off = int'($signed(ins[23:0]));
        tgt = pc + 32'(off * 4);
        lnk = pc - 32'd4;
        return {tk, tgt, lw, lnk, br};
    endfunction

    task automatic compare_one();
        logic [66:0] e;
        string       t;
        bit          bad;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        bad = 1'b0;
        compared++;
        if (is_branch_o !== e[0]) begin
            bad = 1'b1;
            $display("FAIL R1 [%s] is_branch act=%0b exp=%0b", t, is_branch_o, e[0]);
        end
        if (taken_o !== e[66]) begin
            bad = 1'b1;
            $display("FAIL R4 [%s] taken act=%0b exp=%0b", t, taken_o, e[66]);
        end
        if (target_o !== e[65:34]) begin
            bad = 1'b1;
            $display("FAIL R5 [%s] target act=%h exp=%h", t, target_o, e[65:34]);
        end
        if (link_we_o !== e[33]) begin
            bad = 1'b1;
            $display("FAIL R8 [%s] link_we act=%0b exp=%0b", t, link_we_o, e[33]);
        end
        if (link_value_o !== e[32:1]) begin
            bad = 1'b1;
            $display("FAIL R7 [%s] link_value act=%h exp=%h", t, link_value_o, e[32:1]);
        end
        if (bad) mismatched++;
    endtask

    // R9: each output is compared one clock after its inputs were driven
    task automatic step(input logic [31:0] ins, input logic [31:0] pc,
                        input logic [3:0] f, input string tag);
        @(negedge clk);
        if (exp_q.size() != 0) compare_one();
        instr_i = ins;
        pc_i    = pc;
        flags_i = f;
        exp_q.push_back(ref_model(ins, pc, f));
        tag_q.push_back(tag);
    endtask

    task automatic flush();
        @(negedge clk);
        if (exp_q.size() != 0) compare_one();
    endtask

    function automatic logic [31:0] mk(input logic [3:0] cond, input logic [2:0] cls,
                                       input logic lnk, input logic [23:0] off);
        return {cond, cls, lnk, off};
    endfunction

    initial begin
        // R9: reset state, with non-zero inputs applied
        instr_i = mk(4'hE, 3'b101, 1'b1, 24'h000123);
        pc_i    = 32'h1000;
        flags_i = 4'hF;
        repeat (3) @(negedge clk);
        compared++;
        if ({taken_o, target_o, link_we_o, link_value_o, is_branch_o} !== 67'd0) begin
            mismatched++;
            $display("FAIL R9 reset outputs act=%h exp=0",
                     {taken_o, target_o, link_we_o, link_value_o, is_branch_o});
        end
        rst_n = 1'b1;

        // R2 R3: full sweep of condition codes against flag values
        for (int code = 0; code < 16; code++) begin
            for (int fl = 0; fl < 16; fl++) begin
                step(mk(4'(code), 3'b101, 1'(code ^ fl),
                        24'((code * 16 + fl) * 24'h01F3A7)),
                     32'h0000_8008 + 32'(code * 256 + fl * 16), 4'(fl),
                     (code >= 14) ? "R3 cond sweep" : "R2 cond sweep");
            end
        end

        // R6: ends of the reachable window
        step(mk(4'hE, 3'b101, 1'b0, 24'h7FFFFF), 32'h0200_0008, 4'h0, "R6 max fwd");
        step(mk(4'hE, 3'b101, 1'b1, 24'h800000), 32'h0200_0008, 4'h0, "R6 max back");
        // R5: small negative offset and wrap past 2^32
        step(mk(4'hE, 3'b101, 1'b0, 24'hFFFFFF), 32'h0000_1008, 4'h0, "R5 minus one");
        step(mk(4'hE, 3'b101, 1'b0, 24'h000004), 32'hFFFF_FFF8, 4'h0, "R5 wrap");
        step(mk(4'hE, 3'b101, 1'b0, 24'h000000), 32'h0000_0004, 4'h0, "R7 pc small");

        // R10 R1: other instruction classes, with conditions that would pass
        for (int cls = 0; cls < 8; cls++) begin
            if (cls != 5) begin
                step(mk(4'hE, 3'(cls), 1'b1, 24'h00ABCD), 32'h0000_4008, 4'hF, "R10 non-branch");
                step(mk(4'h0, 3'(cls), 1'b1, 24'h800001), 32'h0000_4008, 4'h4, "R1 non-branch eq");
            end
        end

        // R8: link bit with a failing and a passing condition
        step(mk(4'h0, 3'b101, 1'b1, 24'h000010), 32'h0000_2008, 4'h0, "R8 link cond fail");
        step(mk(4'h0, 3'b101, 1'b1, 24'h000010), 32'h0000_2008, 4'h4, "R8 link cond pass");
        step(mk(4'hF, 3'b101, 1'b1, 24'h000010), 32'h0000_2008, 4'hF, "R8 link never");
        step(mk(4'hE, 3'b101, 1'b0, 24'h000010), 32'h0000_2008, 4'h0, "R8 no link bit");
        flush();

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog expired act=running exp=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule